// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block chooses which hardware thread of a multithreaded out-of-order core may retire an instruction in the current commit slot. Every thread presents a state code, a flag that its reorder buffer is empty, a flag that the instruction at the buffer head is ready, and the 16-bit sequence number of that head instruction. A per-thread enable mask tells the selector which threads are configured. The selector answers in the same cycle with a thread index and a valid bit. When no thread qualifies, the valid bit is low.

A two-bit policy input chooses how the winner is picked. The oldest-first policy takes the ready head with the smallest sequence number. The greedy policy uses the same rule. The rotating policy walks an internal priority list, which starts in ascending thread order. Whenever a rotating grant is consumed by a retirement, the winning thread moves to the back of that list. When exactly one thread is enabled, a shortcut returns that thread as soon as its state allows retirement, without looking at the buffer flags.

Top module: `commit_thread_picker`

## Requirements
- R1: Thread state codes are Idle=0, Running=1, Squashing=2, TrapWait=3 and FetchTrapWait=4. Only codes 0, 1 and 4 allow a thread to win. A thread whose enable bit is 0 never wins.
- R2: Under policy 2 (oldest), the candidates are threads that are allowed by R1, have a non-empty buffer and have a ready head. The winner is the candidate with the smallest unsigned sequence number, and a tie goes to the lowest thread index. The output follows the inputs in the same cycle.
- R3: Policy 0 (greedy) and policy 3 select exactly as policy 2 does.
- R4: Under policy 1 (rotate), the winner is the first thread in the priority list, scanned from the front, that is allowed by R1 and has a ready head.
- R5: On a clock edge where `retire_fire` is 1, policy 1 is selected, a grant is valid and the shortcut of R9 is inactive, the winning thread moves to the tail of the priority list. The other threads keep their relative order.
- R6: The priority list does not change on any other edge: when `retire_fire` is 0, when the policy is not 1, when no grant is valid, or when the shortcut is active.
- R7: After reset, the priority list holds the thread indices in ascending order, with thread 0 at the front.
- R8: When no thread qualifies, `pick_valid` is 0 and `pick_idx` is 0.
- R9: When exactly one enable bit is set, that thread is returned under every policy whenever its state is allowed by R1, whatever its empty and ready flags. If its state is not allowed, no thread is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 2 | 0 greedy, 1 rotate, 2 oldest, 3 oldest |
| thr_enable | input | N_THREADS | Configured-thread mask |
| thr_state | input | 3*N_THREADS | Per-thread state code, thread i in bits [3i+2:3i] |
| rob_empty | input | N_THREADS | Per-thread buffer empty flag |
| head_ready | input | N_THREADS | Per-thread head-ready flag |
| head_seq | input | SEQ_W*N_THREADS | Per-thread head sequence number, thread i in bits [SEQ_W*i +: SEQ_W] |
| retire_fire | input | 1 | The current grant is consumed this cycle |
| pick_valid | output | 1 | A thread was selected |
| pick_idx | output | $clog2(N_THREADS) | Selected thread index |

## Verification
The oldest-first rule is tried with distinct sequence numbers, with equal sequence numbers, and with a wrap-like pattern (0xFFFF against 1). These patterns separate a correct unsigned minimum from first-found, signed or tie-breaking errors. Each blocking state code is placed on the thread that would otherwise win, so a wrong eligibility decode changes the answer. The rotating policy is driven through a series of consumed grants with changing ready masks, which shows whether the winner goes to the tail and whether the other threads stay in order. Edges that must not rotate are followed by a full-ready probe of the list front. Single-enabled patterns with empty, unready or blocked threads separate the shortcut from the normal paths.

// File: rtl/thr_pick_pkg.sv
// Shared types for the commit thread selector.
package thr_pick_pkg;

    typedef enum logic [2:0] {
        TS_IDLE            = 3'd0,
        TS_RUNNING         = 3'd1,
        TS_SQUASHING       = 3'd2,
        TS_TRAP_WAIT       = 3'd3,
        TS_FETCH_TRAP_WAIT = 3'd4
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_GREEDY     = 2'd0,
        POL_ROTATE     = 2'd1,
        POL_OLDEST     = 2'd2,
        POL_OLDEST_ALT = 2'd3
    } pick_policy_e;

    localparam int STATE_W = 3;

    // True for the state codes that permit a thread to retire.
    function automatic logic state_can_retire(input logic [STATE_W-1:0] s);
        return (s == TS_IDLE) || (s == TS_RUNNING) || (s == TS_FETCH_TRAP_WAIT);
    endfunction

endpackage

// File: rtl/thr_eligibility.sv
// Per-thread qualification masks.
// Assumes: state codes as in thr_pick_pkg. Produces the three candidate
// masks used by the policy paths, plus the single-enabled-thread flag.
module thr_eligibility
    import thr_pick_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic [N_THREADS-1:0]         thr_enable,
    input  logic [STATE_W*N_THREADS-1:0] thr_state,
    input  logic [N_THREADS-1:0]         rob_empty,
    input  logic [N_THREADS-1:0]         head_ready,
    output logic [N_THREADS-1:0]         state_ok,
    output logic [N_THREADS-1:0]         rotate_ok,
    output logic [N_THREADS-1:0]         oldest_ok,
    output logic                         single_mode
);

    genvar t;
    generate
        for (t = 0; t < N_THREADS; t++) begin : g_thr
            // Decode the state of one thread into its candidate bits.
            always_comb begin
                state_ok[t]  = thr_enable[t] &&
                               state_can_retire(thr_state[STATE_W*t +: STATE_W]);
                rotate_ok[t] = state_ok[t] && head_ready[t];
                oldest_ok[t] = state_ok[t] && head_ready[t] && !rob_empty[t];
            end
        end
    endgenerate

    // Exactly one configured thread enables the shortcut path.
    always_comb single_mode = ($countones(thr_enable) == 1);

endmodule

// File: rtl/oldest_head_pick.sv
// Oldest-head selection among candidate threads.
// Assumes: unsigned sequence numbers. A strict less-than keeps the lowest
// index on ties.
module oldest_head_pick #(
    parameter int N_THREADS = 4,
    parameter int SEQ_W     = 16,
    localparam int IDX_W    = $clog2(N_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_THREADS-1:0]         cand,
    input  logic [SEQ_W*N_THREADS-1:0]   head_seq,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx
);

    logic [SEQ_W-1:0] best_seq;

    // Linear scan keeping the smallest sequence number seen so far.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_seq  = '0;
        for (int i = 0; i < N_THREADS; i++) begin
            if (cand[i] && (!win_valid || head_seq[SEQ_W*i +: SEQ_W] < best_seq)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_seq  = head_seq[SEQ_W*i +: SEQ_W];
            end
        end
    end

    AST_OLDEST_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> cand[win_idx]); // R2
    AST_OLDEST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (cand == '0)); // R8

endmodule

// File: rtl/rr_priority_list.sv
// Rotating priority list with front-first scan.
// Assumes: advance is asserted only when the grant is consumed. The winner
// moves to the tail and the entries behind it shift one place forward.
module rr_priority_list #(
    parameter int N_THREADS = 4,
    localparam int IDX_W    = $clog2(N_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] cand,
    input  logic                 advance,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx
);

    logic [N_THREADS-1:0][IDX_W-1:0] order_q, order_d;
    logic [IDX_W-1:0]                win_pos;
    logic [N_THREADS-1:0]            member;

    // Find the first list slot whose thread is a candidate.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_pos   = '0;
        for (int p = 0; p < N_THREADS; p++) begin
            if (!win_valid && cand[order_q[p]]) begin
                win_valid = 1'b1;
                win_idx   = order_q[p];
                win_pos   = IDX_W'(p);
            end
        end
    end

    // Build the next order with the winner moved to the tail.
    always_comb begin
        order_d = order_q;
        if (advance && win_valid) begin
            for (int p = 0; p < N_THREADS - 1; p++) begin
                if (IDX_W'(p) >= win_pos) order_d[p] = order_q[p+1];
            end
            order_d[N_THREADS-1] = win_idx;
        end
    end

    // Hold the list, loading the ascending order on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N_THREADS; p++) order_q[p] <= IDX_W'(p);
        end else begin
            order_q <= order_d;
        end
    end

    // Membership mask used to check that the list stays a permutation.
    always_comb begin
        member = '0;
        for (int p = 0; p < N_THREADS; p++) member[order_q[p]] = 1'b1;
    end

    AST_LIST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(member) == N_THREADS); // R5
    AST_WINNER_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && win_valid) |=> (order_q[N_THREADS-1] == $past(win_idx))); // R5
    AST_LIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(order_q)); // R6

endmodule

// File: rtl/commit_thread_picker.sv
// Commit-slot thread selector for an SMT core.
// Assumes: N_THREADS in 2..4 and unsigned SEQ_W-bit sequence numbers.
// The selection is combinational. Only the rotating list holds state, and
// it advances on a consumed rotating grant.
module commit_thread_picker
    import thr_pick_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int SEQ_W     = 16,
    localparam int IDX_W    = $clog2(N_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   policy_sel,
    input  logic [N_THREADS-1:0]         thr_enable,
    input  logic [STATE_W*N_THREADS-1:0] thr_state,
    input  logic [N_THREADS-1:0]         rob_empty,
    input  logic [N_THREADS-1:0]         head_ready,
    input  logic [SEQ_W*N_THREADS-1:0]   head_seq,
    input  logic                         retire_fire,
    output logic                         pick_valid,
    output logic [IDX_W-1:0]             pick_idx
);

    logic [N_THREADS-1:0] state_ok, rotate_ok, oldest_ok;
    logic                 single_mode;
    logic                 old_valid, rr_valid, one_valid;
    logic [IDX_W-1:0]     old_idx, rr_idx, one_idx;
    logic                 rr_advance;

    thr_eligibility #(.N_THREADS(N_THREADS)) i_elig (
        .thr_enable (thr_enable),
        .thr_state  (thr_state),
        .rob_empty  (rob_empty),
        .head_ready (head_ready),
        .state_ok   (state_ok),
        .rotate_ok  (rotate_ok),
        .oldest_ok  (oldest_ok),
        .single_mode(single_mode)
    );

    oldest_head_pick #(.N_THREADS(N_THREADS), .SEQ_W(SEQ_W)) i_oldest (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (oldest_ok),
        .head_seq (head_seq),
        .win_valid(old_valid),
        .win_idx  (old_idx)
    );

    rr_priority_list #(.N_THREADS(N_THREADS)) i_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (rotate_ok),
        .advance  (rr_advance),
        .win_valid(rr_valid),
        .win_idx  (rr_idx)
    );

    // Shortcut path: the index of the one enabled thread, if its state allows.
    always_comb begin
        one_idx = '0;
        for (int i = 0; i < N_THREADS; i++) begin
            if (thr_enable[i]) one_idx = IDX_W'(i);
        end
        one_valid = state_ok[one_idx];
    end

    // Policy mux, with the shortcut taking precedence.
    always_comb begin
        if (single_mode) begin
            pick_valid = one_valid;
            pick_idx   = one_valid ? one_idx : '0;
        end else if (policy_sel == POL_ROTATE) begin
            pick_valid = rr_valid;
            pick_idx   = rr_idx;
        end else begin
            pick_valid = old_valid;
            pick_idx   = old_idx;
        end
    end

    // Rotate only when a rotating grant is consumed.
    always_comb rr_advance = retire_fire && !single_mode && (policy_sel == POL_ROTATE);

    AST_PICK_STATE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (thr_enable[pick_idx] &&
                        state_can_retire(thr_state[STATE_W*pick_idx +: STATE_W]))); // R1
    AST_NONE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> (pick_idx == '0)); // R8
    AST_SHARED_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && $countones(thr_enable) > 1) |-> head_ready[pick_idx]); // R4

endmodule

// File: tb/test_commit_thread_picker.sv
module test_commit_thread_picker;

    localparam int N   = 4;
    localparam int SW  = 16;
    localparam int IW  = 2;

    typedef struct packed {
        logic [1:0]    pol;
        logic [3:0]    en;
        logic [11:0]   st;
        logic [3:0]    emp;
        logic [3:0]    rdy;
        logic [63:0]   seq;
        logic          ev;
        logic [1:0]    ei;
        logic [7:0]    req;
    } vec_t;

    localparam logic [63:0] SQA = {16'd40, 16'd10, 16'd30, 16'd20};
    localparam logic [63:0] SQE = {16'd5, 16'd5, 16'd5, 16'd5};
    localparam logic [63:0] SQW = {16'd100, 16'd200, 16'd1, 16'hFFFF};
    localparam int NV = 22;

    localparam vec_t VECS [NV] = '{
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'hF, SQA, 1'b1, 2'd2, 8'd2},  // R2 oldest is t2
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'hB, SQA, 1'b1, 2'd0, 8'd2},  // R2 t2 not ready
        '{2'd0, 4'hF, 12'h249, 4'h0, 4'hF, SQA, 1'b1, 2'd2, 8'd3},  // R3 greedy
        '{2'd3, 4'hF, 12'h249, 4'h0, 4'hF, SQA, 1'b1, 2'd2, 8'd3},  // R3 code 3
        '{2'd2, 4'hF, 12'h289, 4'h0, 4'hF, SQA, 1'b1, 2'd0, 8'd1},  // R1 squashing blocks
        '{2'd2, 4'hF, 12'h2C9, 4'h0, 4'hF, SQA, 1'b1, 2'd0, 8'd1},  // R1 trap wait blocks
        '{2'd2, 4'hF, 12'h309, 4'h0, 4'hF, SQA, 1'b1, 2'd2, 8'd1},  // R1 fetch trap wait ok
        '{2'd2, 4'hF, 12'h209, 4'h0, 4'hF, SQA, 1'b1, 2'd2, 8'd1},  // R1 idle ok
        '{2'd2, 4'hB, 12'h249, 4'h0, 4'hF, SQA, 1'b1, 2'd0, 8'd1},  // R1 disabled thread
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'hF, SQE, 1'b1, 2'd0, 8'd2},  // R2 tie lowest
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'hE, SQE, 1'b1, 2'd1, 8'd2},  // R2 tie lowest ready
        '{2'd2, 4'hF, 12'h249, 4'h4, 4'hF, SQA, 1'b1, 2'd0, 8'd2},  // R2 empty excluded
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'h0, SQA, 1'b0, 2'd0, 8'd8},  // R8 oldest none
        '{2'd1, 4'hF, 12'h249, 4'h0, 4'h0, SQA, 1'b0, 2'd0, 8'd8},  // R8 rotate none
        '{2'd1, 4'hF, 12'h249, 4'h0, 4'hC, SQA, 1'b1, 2'd2, 8'd4},  // R4 first ready in list
        '{2'd1, 4'hF, 12'h249, 4'h0, 4'hF, SQA, 1'b1, 2'd0, 8'd7},  // R7 front is t0
        '{2'd2, 4'h4, 12'h249, 4'h4, 4'h0, SQA, 1'b1, 2'd2, 8'd9},  // R9 single oldest
        '{2'd1, 4'h4, 12'h249, 4'h4, 4'h0, SQA, 1'b1, 2'd2, 8'd9},  // R9 single rotate
        '{2'd2, 4'h4, 12'h289, 4'h0, 4'hF, SQA, 1'b0, 2'd0, 8'd9},  // R9 single blocked
        '{2'd2, 4'hF, 12'h249, 4'h0, 4'hF, SQW, 1'b1, 2'd1, 8'd2},  // R2 unsigned compare
        '{2'd1, 4'hF, 12'h2C9, 4'h0, 4'hC, SQA, 1'b1, 2'd3, 8'd4},  // R4 skip blocked t2
        '{2'd0, 4'hF, 12'h249, 4'h0, 4'h0, SQA, 1'b0, 2'd0, 8'd8}   // R8 greedy none
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    policy_sel = 2'd2;
    logic [N-1:0]  thr_enable = '1;
    logic [3*N-1:0] thr_state = 12'h249;
    logic [N-1:0]  rob_empty = '0;
    logic [N-1:0]  head_ready = '0;
    logic [SW*N-1:0] head_seq = SQA;
    logic          retire_fire = 1'b0;
    logic          pick_valid;
    logic [IW-1:0] pick_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    commit_thread_picker #(.N_THREADS(N), .SEQ_W(SW)) i_commit_thread_picker (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_sel (policy_sel),
        .thr_enable (thr_enable),
        .thr_state  (thr_state),
        .rob_empty  (rob_empty),
        .head_ready (head_ready),
        .head_seq   (head_seq),
        .retire_fire(retire_fire),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    task automatic drive(input logic [1:0] pol, input logic [3:0] en,
                         input logic [11:0] st, input logic [3:0] emp,
                         input logic [3:0] rdy, input logic [63:0] sq);
        @(negedge clk);
        policy_sel = pol; thr_enable = en; thr_state = st;
        rob_empty = emp; head_ready = rdy; head_seq = sq;
        #2;
    endtask

    task automatic check(input logic ev, input logic [1:0] ei, input string tag);
        n_tests++;
        if (pick_valid !== ev || pick_idx !== ei) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, pick_valid, pick_idx, ev, ei);
        end
    endtask

    task automatic fire();
        @(negedge clk);
        retire_fire = 1'b1;
        @(posedge clk);
        #1 retire_fire = 1'b0;
    endtask

    task automatic rr_probe(input logic [1:0] ei, input string tag);
        drive(2'd1, 4'hF, 12'h249, 4'h0, 4'hF, SQA);
        check(1'b1, ei, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7 / R8 reset-state check: list front after reset, no qualifiers
        drive(2'd1, 4'hF, 12'h249, 4'h0, 4'h0, SQA);
        check(1'b0, 2'd0, "R8 after reset");

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].pol, VECS[v].en, VECS[v].st, VECS[v].emp,
                  VECS[v].rdy, VECS[v].seq);
            check(VECS[v].ev, VECS[v].ei, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end

        // R5 rotation sequence
        rr_probe(2'd0, "R7 front before rotation");
        fire();                              // list 1,2,3,0
        rr_probe(2'd1, "R5 after first rotation");
        fire();                              // list 2,3,0,1
        rr_probe(2'd2, "R5 after second rotation");
        drive(2'd1, 4'hF, 12'h249, 4'h0, 4'h9, SQA);
        check(1'b1, 2'd3, "R4 scan from rotated list");
        fire();                              // list 2,0,1,3
        rr_probe(2'd2, "R5 others keep order");
        drive(2'd1, 4'hF, 12'h249, 4'h0, 4'hB, SQA);
        check(1'b1, 2'd0, "R5 second slot after move");

        // R6 no rotation under oldest policy
        drive(2'd2, 4'hF, 12'h249, 4'h0, 4'hF, SQA);
        fire();
        rr_probe(2'd2, "R6 oldest policy fire");
        // R6 no rotation without a valid grant
        drive(2'd1, 4'hF, 12'h249, 4'h0, 4'h0, SQA);
        fire();
        rr_probe(2'd2, "R6 fire with no grant");
        // R6 no rotation in single mode
        drive(2'd1, 4'h1, 12'h249, 4'h0, 4'hF, SQA);
        check(1'b1, 2'd0, "R9 single thread under rotate");
        fire();
        rr_probe(2'd2, "R6 single mode fire");
        // R6 idle cycles
        repeat (3) @(posedge clk);
        rr_probe(2'd2, "R6 no fire holds list");

        // R7 reset restores ascending order
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rr_probe(2'd0, "R7 list after second reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule